// File: doc/BRIEF.md
# Address Decoder with Boot Overlay

This block sits between a CPU's 16-bit address bus and its on-chip memories. Each cycle it classifies the current address into one of eight regions and raises one select line for that region. It forms the offset inside the region and gates the write strobe per region. Read data from the memory arrays, which sit outside the block, comes back through the block: it selects the right array, substitutes zero for the sprite-attribute and I/O windows, and registers the result, so read data appears one cycle after the request.

After reset, a small start-up program occupies the lowest 256 addresses, covering the start of cartridge ROM. The start-up code pulses a disable input when it is finished. The overlay then drops away for good and the low addresses reach cartridge ROM again. Work RAM is seen twice: once at its home window and again in a mirror that runs up to the sprite page. The top 128 bytes are a separate small fast RAM.

Top module: `addr_map_decoder`

## Requirements
- R1: For every address exactly one bit of `region_sel` is high. The bit order is: 0 boot, 1 cartridge ROM, 2 video RAM, 3 external RAM, 4 work RAM, 5 sprite attributes, 6 I/O, 7 high RAM.
- R2: `boot_active` is 1 after reset. While it is 1, addresses 0x0000–0x00FF select bit 0 with offset addr[7:0], and a read returns `boot_rdata`.
- R3: If `boot_off` is high at a rising edge, `boot_active` is 0 from the next cycle. It stays 0 until the next reset. Decoding in the cycle of the pulse still uses the old flag.
- R4: Addresses 0x0000–0x7FFF that the overlay does not claim select bit 1 with offset addr[14:0]. Reads return `rom_rdata`.
- R5: 0x8000–0x9FFF selects bit 2 and 0xA000–0xBFFF selects bit 3, both with offset addr[12:0]. Reads return `vram_rdata` and `xram_rdata` respectively.
- R6: 0xC000–0xDFFF and its mirror 0xE000–0xFDFF both select bit 4 with offset addr[12:0]. Reads return `wram_rdata`.
- R7: 0xFE00–0xFEFF selects bit 5 with offset addr[7:0]. 0xFF00–0xFF7F selects bit 6 with offset addr[6:0]. Reads from either window return 0x00.
- R8: 0xFF80–0xFFFF selects bit 7 with offset addr[6:0]. Reads return `hram_rdata`.
- R9: `region_wr` equals `region_sel` while `cpu_wr` is high and is all zero otherwise. Bits 0 and 1 (boot and ROM) are always 0, so writes to those regions are ignored.
- R10: `cpu_rvalid` is `cpu_rd` delayed by one cycle. `cpu_rdata` takes the selected region's data at each edge where `cpu_rd` is high and holds otherwise. Both reset to 0.
- R11: In `region_off`, bits above a region's offset width are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_off | input | 1 | Pulse that retires the boot overlay |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| boot_rdata | input | DATA_W | Data from start-up program array |
| rom_rdata | input | DATA_W | Data from cartridge ROM array |
| vram_rdata | input | DATA_W | Data from video RAM |
| xram_rdata | input | DATA_W | Data from external RAM |
| wram_rdata | input | DATA_W | Data from work RAM |
| hram_rdata | input | DATA_W | Data from high RAM |
| region_sel | output | 8 | One-hot region select |
| region_wr | output | 8 | Per-region write strobe |
| region_off | output | 15 | Offset inside selected region |
| boot_active | output | 1 | Overlay currently mapped |
| cpu_rdata | output | DATA_W | Registered read data |
| cpu_rvalid | output | 1 | Read data valid |

## Verification
The bench first walks the first and last address of every window, once as reads and once as writes. This separates off-by-one boundary errors and shows whether each window maps to the right data source and strobe. The same walk is repeated after the overlay is retired, which tells the overlay region apart from the ROM underneath it. A long run of random addresses with mixed reads, writes and occasional disable pulses exercises the mirror, the offset masks and the read-data holding behaviour. A final reset shows that the overlay returns.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

    localparam int ADDR_W   = 16;
    localparam int NREG     = 8;
    localparam int OFF_W    = 15;

    localparam int BOOT_OFF_W = 8;
    localparam int ROM_OFF_W  = 15;
    localparam int BANK_OFF_W = 13;
    localparam int SPR_OFF_W  = 8;
    localparam int IO_OFF_W   = 7;
    localparam int HRAM_OFF_W = 7;

    localparam logic [ADDR_W-1:0] BOOT_LIMIT = 16'h0100;
    localparam logic [ADDR_W-1:0] VRAM_BASE  = 16'h8000;
    localparam logic [ADDR_W-1:0] XRAM_BASE  = 16'hA000;
    localparam logic [ADDR_W-1:0] WRAM_BASE  = 16'hC000;
    localparam logic [ADDR_W-1:0] SPR_BASE   = 16'hFE00;
    localparam logic [ADDR_W-1:0] IO_BASE    = 16'hFF00;
    localparam logic [ADDR_W-1:0] HRAM_BASE  = 16'hFF80;

    typedef enum logic [2:0] {
        RG_BOOT = 3'd0,
        RG_ROM  = 3'd1,
        RG_VRAM = 3'd2,
        RG_XRAM = 3'd3,
        RG_WRAM = 3'd4,
        RG_SPR  = 3'd5,
        RG_IO   = 3'd6,
        RG_HRAM = 3'd7
    } region_e;

    // regions that never accept a write
    localparam logic [NREG-1:0] WR_BLOCK = 8'b0000_0011;

endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
    import addr_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              overlay_on,
    output region_e           region,
    output logic [NREG-1:0]   sel
);

    always_comb begin
        if (overlay_on && (addr < BOOT_LIMIT)) begin
            region = RG_BOOT;
        end else if (addr < VRAM_BASE) begin
            region = RG_ROM;
        end else if (addr < XRAM_BASE) begin
            region = RG_VRAM;
        end else if (addr < WRAM_BASE) begin
            region = RG_XRAM;
        end else if (addr < SPR_BASE) begin
            region = RG_WRAM;   // home window and mirror
        end else if (addr < IO_BASE) begin
            region = RG_SPR;
        end else if (addr < HRAM_BASE) begin
            region = RG_IO;
        end else begin
            region = RG_HRAM;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = (region == region_e'(g));
    end

endmodule

// File: rtl/addr_offset_gen.sv
module addr_offset_gen
    import addr_map_pkg::*;
(
    input  logic [OFF_W-1:0] addr_lo,
    input  region_e          region,
    output logic [OFF_W-1:0] off
);

    always_comb begin
        off = '0;
        unique case (region)
            RG_BOOT: off[BOOT_OFF_W-1:0] = addr_lo[BOOT_OFF_W-1:0];
            RG_ROM:  off[ROM_OFF_W-1:0]  = addr_lo[ROM_OFF_W-1:0];
            RG_VRAM,
            RG_XRAM,
            RG_WRAM: off[BANK_OFF_W-1:0] = addr_lo[BANK_OFF_W-1:0];
            RG_SPR:  off[SPR_OFF_W-1:0]  = addr_lo[SPR_OFF_W-1:0];
            RG_IO:   off[IO_OFF_W-1:0]   = addr_lo[IO_OFF_W-1:0];
            RG_HRAM: off[HRAM_OFF_W-1:0] = addr_lo[HRAM_OFF_W-1:0];
            default: off = '0;
        endcase
    end

endmodule

// File: rtl/addr_read_mux.sv
module addr_read_mux
    import addr_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  region_e           region,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic [DATA_W-1:0] xram_rdata,
    input  logic [DATA_W-1:0] wram_rdata,
    input  logic [DATA_W-1:0] hram_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DATA_W-1:0] pick;

    always_comb begin
        unique case (region)
            RG_BOOT: pick = boot_rdata;
            RG_ROM:  pick = rom_rdata;
            RG_VRAM: pick = vram_rdata;
            RG_XRAM: pick = xram_rdata;
            RG_WRAM: pick = wram_rdata;
            RG_HRAM: pick = hram_rdata;
            default: pick = '0;        // sprite and I/O windows
        endcase

        st_d       = st_q;
        st_d.valid = rd;
        if (rd) begin
            st_d.data = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.data;
    assign rvalid = st_q.valid;

endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import addr_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_off,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic [DATA_W-1:0] xram_rdata,
    input  logic [DATA_W-1:0] wram_rdata,
    input  logic [DATA_W-1:0] hram_rdata,
    output logic [7:0]        region_sel,
    output logic [7:0]        region_wr,
    output logic [14:0]       region_off,
    output logic              boot_active,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid
);

    typedef struct packed {
        logic overlay;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    region_e    region;
    logic [NREG-1:0] sel;

    always_comb begin
        ctl_d = ctl_q;
        if (boot_off) begin
            ctl_d.overlay = 1'b0;  // sticky until reset
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.overlay <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    addr_region_decode u_decode (
        .addr       (cpu_addr),
        .overlay_on (ctl_q.overlay),
        .region     (region),
        .sel        (sel)
    );

    addr_offset_gen u_offset (
        .addr_lo (cpu_addr[OFF_W-1:0]),
        .region  (region),
        .off     (region_off)
    );

    addr_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .clk        (clk),
        .rst        (rst),
        .rd         (cpu_rd),
        .region     (region),
        .boot_rdata (boot_rdata),
        .rom_rdata  (rom_rdata),
        .vram_rdata (vram_rdata),
        .xram_rdata (xram_rdata),
        .wram_rdata (wram_rdata),
        .hram_rdata (hram_rdata),
        .rdata      (cpu_rdata),
        .rvalid     (cpu_rvalid)
    );

    always_comb begin
        region_sel = sel;
        region_wr  = cpu_wr ? (sel & ~WR_BLOCK) : '0;
    end

    assign boot_active = ctl_q.overlay;

endmodule

// File: rtl/addr_map_chk.sv
module addr_map_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              boot_off,
    input logic [15:0]       cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        region_sel,
    input logic [7:0]        region_wr,
    input logic              boot_active,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_rvalid
);

    p_onehot_sel_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(region_sel) == 1);

    p_boot_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> boot_active);

    p_boot_overlay_r2: assert property (@(posedge clk) disable iff (rst)
        (boot_active && cpu_addr < 16'h0100) |-> region_sel[0]);

    p_boot_clear_r3: assert property (@(posedge clk) disable iff (rst)
        boot_off |=> !boot_active);

    p_boot_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !boot_active |=> !boot_active);

    p_zero_window_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && (region_sel[5] || region_sel[6])) |=> cpu_rdata == '0);

    p_hram_window_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= 16'hFF80) |-> region_sel[7]);

    p_no_rom_write_r9: assert property (@(posedge clk) disable iff (rst)
        region_wr[1:0] == 2'b00);

    p_idle_write_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr |-> region_wr == 8'h00);

    p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_rd |=> cpu_rvalid);

    p_no_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> !cpu_rvalid);

    p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd && !$past(rst)) |=> $stable(cpu_rdata));

endmodule

bind addr_map_decoder addr_map_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .boot_off    (boot_off),
    .cpu_addr    (cpu_addr),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .region_sel  (region_sel),
    .region_wr   (region_wr),
    .boot_active (boot_active),
    .cpu_rdata   (cpu_rdata),
    .cpu_rvalid  (cpu_rvalid)
);

// File: tb/tb_addr_map_decoder.sv
`timescale 1ns/1ps
module tb_addr_map_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_off = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  boot_rdata = '0, rom_rdata = '0, vram_rdata = '0;
    logic [7:0]  xram_rdata = '0, wram_rdata = '0, hram_rdata = '0;
    logic [7:0]  region_sel, region_wr;
    logic [14:0] region_off;
    logic        boot_active;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;

    always #2 clk = ~clk;

    addr_map_decoder #(.DATA_W(8)) dut (
        .clk(clk), .rst(rst), .boot_off(boot_off), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .boot_rdata(boot_rdata), .rom_rdata(rom_rdata), .vram_rdata(vram_rdata),
        .xram_rdata(xram_rdata), .wram_rdata(wram_rdata), .hram_rdata(hram_rdata),
        .region_sel(region_sel), .region_wr(region_wr), .region_off(region_off),
        .boot_active(boot_active), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit m_boot = 1'b1;
    bit m_rvalid = 1'b0;
    int m_rdata = 0;
    bit done = 1'b0;

    int edges[$] = '{'h0000, 'h00FF, 'h0100, 'h7FFF, 'h8000, 'h9FFF, 'hA000,
                     'hBFFF, 'hC000, 'hDFFF, 'hE000, 'hFDFF, 'hFE00, 'hFEFF,
                     'hFF00, 'hFF7F, 'hFF80, 'hFFFF};

    function automatic int ref_region(int a, bit b);
        if (b && a < 'h100)  return 0;
        if (a < 'h8000)      return 1;
        if (a < 'hA000)      return 2;
        if (a < 'hC000)      return 3;
        if (a < 'hFE00)      return 4;
        if (a < 'hFF00)      return 5;
        if (a < 'hFF80)      return 6;
        return 7;
    endfunction

    function automatic int ref_offset(int a, int r);
        case (r)
            0, 5:    return a % 256;
            1:       return a % 32768;
            2, 3, 4: return a % 8192;
            default: return a % 128;
        endcase
    endfunction

    function automatic int src(int r, int a);
        return (a * 7 + r * 41 + (a / 256)) % 256;
    endfunction

    function automatic string tag(int r);
        case (r)
            0:       return "R2";
            1:       return "R4";
            2, 3:    return "R5";
            4:       return "R6";
            5, 6:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string t, int act, int exp, string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    task automatic step(int a, bit rd, bit wr, bit off);
        int r;
        @(negedge clk);
        cpu_addr   = 16'(a);
        cpu_rd     = rd;
        cpu_wr     = wr;
        boot_off   = off;
        boot_rdata = 8'(src(0, a));
        rom_rdata  = 8'(src(1, a));
        vram_rdata = 8'(src(2, a));
        xram_rdata = 8'(src(3, a));
        wram_rdata = 8'(src(4, a));
        hram_rdata = 8'(src(7, a));
        #1;
        r = ref_region(a, m_boot);
        check("R1", int'(region_sel), 1 << r, "select");
        check(tag(r), int'(region_off), ref_offset(a, r), "offset");
        // R11: upper offset bits zero is covered by the full-width compare
        check("R9", int'(region_wr), (wr && r > 1) ? (1 << r) : 0, "write strobe");
        check("R3", int'(boot_active), int'(m_boot), "boot flag");
        check("R10", int'(cpu_rvalid), int'(m_rvalid), "rvalid");
        check("R10", int'(cpu_rdata), m_rdata, "rdata");
        m_rvalid = rd;
        if (rd) m_rdata = (r == 5 || r == 6) ? 0 : src(r, a);
        if (off) m_boot = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0; boot_off = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_boot = 1'b1; m_rvalid = 1'b0; m_rdata = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: reset state and overlay window
        foreach (edges[i]) step(edges[i], 1'b1, 1'b0, 1'b0);
        foreach (edges[i]) step(edges[i], 1'b0, 1'b1, 1'b0);
        step('h0040, 1'b0, 1'b0, 1'b0);
        // R3: disable pulse together with an overlay read
        step('h0010, 1'b1, 1'b0, 1'b1);
        step('h0010, 1'b1, 1'b0, 1'b0);
        foreach (edges[i]) step(edges[i], 1'b1, 1'b0, 1'b0);
        foreach (edges[i]) step(edges[i], 1'b1, 1'b1, 1'b0);
        // random traffic, overlay re-armed first
        do_reset();
        for (int k = 0; k < 600; k++) begin
            int a = int'($urandom_range(0, 65535));
            if (k % 3 == 0) a = a % 512;
            step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 99) == 0));
        end
        // R2/R3: reset restores overlay
        do_reset();
        step('h0020, 1'b1, 1'b0, 1'b0);
        step('h00FF, 1'b1, 1'b0, 1'b0);
        step('hFFFF, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule